// File: doc/BRIEF.md
# Program Counter with Conditional Relative Jump

This block keeps the 16-bit program counter of a small processor core and picks its next value every clock. The fetch stage tells it how many words the instruction just fetched took. The decode stage hands over a whole jump instruction word. The execute stage can force a new address directly. The live N, Z, C and V flags arrive as plain inputs. The block only reads these flags and never changes them.

For a jump word, the block checks the 3-bit condition against the flags. If the jump is taken, the next PC is the current PC plus 2 plus twice the sign-extended 10-bit word offset. If it is not taken, the PC moves past the one-word jump. A registered taken flag marks the cycle in which a jump target appears on the PC output.

Every input is a single-cycle strobe and every output is plain state. There is no data stream, so the block applies no valid/ready handshake and no back-pressure: each strobe counts in the cycle it is high.

Top module: `pcj_core`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the PC loads parameter `RST_ADDR` with bit 0 forced to zero, and `taken_o` goes low.
- R2: Bit 0 of `pc_o` is always zero, and a branch load writes `br_addr` with bit 0 cleared.
- R3: With only `adv_en` high, the PC grows by 2, 4 or 6 for `adv_words` = 1, 2 or 3. With `adv_words` = 0, or with no strobe high, the PC holds its value.
- R4: A jump word has bits 15..13 = 001 (opcode), bits 12..10 = condition and bits 9..0 = two's-complement word offset. When `jmp_en` comes with any other opcode, the word is treated as a jump that is not taken.
- R5: The conditions are: 000 taken if Z=0, 001 if Z=1, 010 if C=0, 011 if C=1, 100 if N=1, 101 if N==V, 110 if N!=V, and 111 always taken.
- R6: A taken jump loads PC + 2 + 2*offset, modulo 2^16. The reach is therefore -511 to +512 words from the jump instruction.
- R7: A jump that is not taken advances the PC by exactly 2.
- R8: Priority is branch load first, then jump, then fetch advance. A lower-priority strobe in the same cycle has no effect.
- R9: `taken_o` is high for exactly the cycle after a taken jump, which is the cycle its target shows on `pc_o`. It is low after every other kind of update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Fetch advance strobe |
| adv_words | input | 2 | Length of the fetched instruction in words |
| jmp_en | input | 1 | Jump instruction strobe |
| jmp_word | input | 16 | Jump instruction word |
| br_en | input | 1 | Direct branch load strobe |
| br_addr | input | 16 | Branch load address |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_o | output | 16 | Program counter |
| taken_o | output | 1 | Previous update was a taken jump |

## Verification
The branch load and the jump evaluation can fall in the same cycle. So can a jump and a fetch advance. The random stimulus raises these strobes on their own and in every overlap, and directed cycles put a taken jump together with a branch load. Each result is judged against a bench model that applies the stated priority: the PC must equal the cleared branch address, or the jump outcome, and `taken_o` must stay low whenever the branch load wins.

// File: rtl/pcj_pkg.sv
package pcj_pkg;
  typedef enum logic [2:0] {
    CC_ZCLR = 3'd0,
    CC_ZSET = 3'd1,
    CC_CCLR = 3'd2,
    CC_CSET = 3'd3,
    CC_NSET = 3'd4,
    CC_SGE  = 3'd5,
    CC_SLT  = 3'd6,
    CC_ALW  = 3'd7
  } cc_e;

  localparam logic [2:0] JMP_OPCODE = 3'b001;
endpackage

// File: rtl/pcj_cond.sv
module pcj_cond
  import pcj_pkg::*;
(
  input  cc_e  cc,
  input  logic fn,
  input  logic fz,
  input  logic fc,
  input  logic fv,
  output logic hit
);
  always_comb begin
    unique case (cc)
      CC_ZCLR: hit = ~fz;
      CC_ZSET: hit = fz;
      CC_CCLR: hit = ~fc;
      CC_CSET: hit = fc;
      CC_NSET: hit = fn;
      CC_SGE:  hit = ~(fn ^ fv);
      CC_SLT:  hit = fn ^ fv;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pcj_target.sv
module pcj_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  tgt
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] byte_off;

  // sign-extend the word offset and scale it to bytes
  assign byte_off = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
  assign tgt      = pc + PC_W'(2) + byte_off;
endmodule

// File: rtl/pcj_step.sv
module pcj_step #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] pc,
  input  logic [1:0]      words,
  output logic [PC_W-1:0] nxt
);
  assign nxt = pc + PC_W'({words, 1'b0});
endmodule

// File: rtl/pcj_core.sv
module pcj_core #(
  parameter int              PC_W     = 16,
  parameter int              OFF_W    = 10,
  parameter logic [PC_W-1:0] RST_ADDR = 16'hC000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_en,
  input  logic [1:0]           adv_words,
  input  logic                 jmp_en,
  input  logic [OFF_W+5:0]     jmp_word,
  input  logic                 br_en,
  input  logic [PC_W-1:0]      br_addr,
  input  logic                 flag_n,
  input  logic                 flag_z,
  input  logic                 flag_c,
  input  logic                 flag_v,
  output logic [PC_W-1:0]      pc_o,
  output logic                 taken_o
);
  import pcj_pkg::*;

  localparam int              CC_LSB   = OFF_W;
  localparam int              OPC_LSB  = OFF_W + 3;
  localparam logic [PC_W-1:0] EVEN_MSK = ~PC_W'(1);
  localparam logic [PC_W-1:0] RST_EVEN = RST_ADDR & EVEN_MSK;

  logic [PC_W-1:0] pc_q, pc_d, jmp_tgt, adv_pc, seq_pc;
  logic            tk_q, tk_d;
  logic            is_jmp, cc_hit;
  cc_e             cc;

  assign is_jmp = (jmp_word[OPC_LSB +: 3] == JMP_OPCODE);
  assign cc     = cc_e'(jmp_word[CC_LSB +: 3]);
  assign seq_pc = pc_q + PC_W'(2);

  pcj_cond u_cond (
    .cc  (cc),
    .fn  (flag_n),
    .fz  (flag_z),
    .fc  (flag_c),
    .fv  (flag_v),
    .hit (cc_hit)
  );

  pcj_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc  (pc_q),
    .off (jmp_word[OFF_W-1:0]),
    .tgt (jmp_tgt)
  );

  pcj_step #(.PC_W(PC_W)) u_step (
    .pc    (pc_q),
    .words (adv_words),
    .nxt   (adv_pc)
  );

  // branch load > jump > fetch advance > hold
  always_comb begin
    pc_d = pc_q;
    tk_d = 1'b0;
    if (br_en) begin
      pc_d = br_addr & EVEN_MSK;
    end else if (jmp_en) begin
      if (is_jmp && cc_hit) begin
        pc_d = jmp_tgt;
        tk_d = 1'b1;
      end else begin
        pc_d = seq_pc;
      end
    end else if (adv_en) begin
      pc_d = adv_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RST_EVEN;
      tk_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      tk_q <= tk_d;
    end
  end

  assign pc_o    = pc_q;
  assign taken_o = tk_q;
endmodule

// File: rtl/pcj_chk.sv
module pcj_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            adv_en,
  input logic            jmp_en,
  input logic            br_en,
  input logic [PC_W-1:0] br_addr,
  input logic [PC_W-1:0] pc_o,
  input logic            taken_o
);
  a_r2_pc_even: assert property (@(posedge clk) disable iff (rst)
    !pc_o[0]);

  a_r8_branch_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(br_en)) |-> (pc_o == ($past(br_addr) & ~PC_W'(1))));

  a_r7_not_taken_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(jmp_en) && !$past(br_en) && !taken_o)
      |-> (pc_o == PC_W'($past(pc_o) + PC_W'(2))));

  a_r9_taken_source: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ($past(jmp_en) && !$past(br_en)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv_en) && !$past(jmp_en) && !$past(br_en))
      |-> $stable(pc_o));
endmodule

bind pcj_core pcj_chk #(.PC_W(PC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .adv_en  (adv_en),
  .jmp_en  (jmp_en),
  .br_en   (br_en),
  .br_addr (br_addr),
  .pc_o    (pc_o),
  .taken_o (taken_o)
);

// File: tb/sim_pcj_core.sv
module sim_pcj_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [1:0]  adv_words = 2'd0;
  logic        jmp_en = 1'b0;
  logic [15:0] jmp_word = 16'h0;
  logic        br_en = 1'b0;
  logic [15:0] br_addr = 16'h0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic [15:0] pc_o;
  logic        taken_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] mpc;
  logic        mtk;

  always #4 clk = ~clk;

  pcj_core #(.RST_ADDR(16'h8003)) u0 (
    .clk(clk), .rst(rst), .adv_en(adv_en), .adv_words(adv_words),
    .jmp_en(jmp_en), .jmp_word(jmp_word), .br_en(br_en), .br_addr(br_addr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .pc_o(pc_o), .taken_o(taken_o)
  );

  function automatic bit cond_ok(input logic [2:0] cc, input logic n, z, c, v);
    case (cc)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] jtarget(input logic [15:0] pc, input logic [9:0] off);
    logic signed [15:0] s;
    s = 16'(signed'(off));
    return pc + 16'd2 + 16'(s * 2);
  endfunction

  task automatic check(input string tag, input logic [15:0] apc, epc, input logic atk, etk);
    total++;
    if (apc !== epc || atk !== etk) begin
      bad++;
      $display("FAIL %s pc=%h taken=%b expected pc=%h taken=%b", tag, apc, atk, epc, etk);
    end
  endtask

  // apply one cycle of stimulus, update the model, then check after the edge
  task automatic cyc(input logic a, input logic [1:0] aw, input logic j, input logic [15:0] jw,
                     input logic b, input logic [15:0] ba, input logic [3:0] fl, input string tag);
    logic [15:0] epc;
    logic        etk;
    adv_en = a; adv_words = aw; jmp_en = j; jmp_word = jw; br_en = b; br_addr = ba;
    {flag_n, flag_z, flag_c, flag_v} = fl;
    epc = mpc; etk = 1'b0;
    if (b) epc = ba & 16'hFFFE;
    else if (j) begin
      if (jw[15:13] == 3'b001 && cond_ok(jw[12:10], fl[3], fl[2], fl[1], fl[0])) begin
        epc = jtarget(mpc, jw[9:0]); etk = 1'b1;
      end else epc = mpc + 16'd2;
    end else if (a) epc = mpc + 16'({aw, 1'b0});
    mpc = epc; mtk = etk;
    @(posedge clk);
    @(negedge clk);
    check(tag, pc_o, mpc, taken_o, mtk);
    if (pc_o[0] !== 1'b0) begin
      total++; bad++;
      $display("FAIL R2 odd pc=%h expected bit0=0", pc_o);
    end
  endtask

  task automatic idle;
    adv_en = 0; jmp_en = 0; br_en = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mpc = 16'h8002; mtk = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset value has bit 0 cleared
    check("R1", pc_o, 16'h8002, taken_o, 1'b0);
    rst = 1'b0;

    // R3: advance by 1,2,3 words and hold on 0 / idle
    cyc(1, 2'd1, 0, 16'h0, 0, 16'h0, 4'h0, "R3");
    cyc(1, 2'd2, 0, 16'h0, 0, 16'h0, 4'h0, "R3");
    cyc(1, 2'd3, 0, 16'h0, 0, 16'h0, 4'h0, "R3");
    cyc(1, 2'd0, 0, 16'h0, 0, 16'h0, 4'h0, "R3");
    cyc(0, 2'd3, 0, 16'h0, 0, 16'h0, 4'h0, "R3");

    // R2: odd branch address is cleared
    cyc(0, 2'd0, 0, 16'h0, 1, 16'h1235, 4'h0, "R2");

    // R6: 0x2FE4 with C=1 jumps back 56 bytes past +2; R7 with C=0
    cyc(0, 2'd0, 1, 16'h2FE4, 0, 16'h0, 4'b0010, "R6");
    cyc(0, 2'd0, 1, 16'h2FE4, 0, 16'h0, 4'b0000, "R7");
    // R6: reach extremes +511 and -512 word offsets (unconditional)
    cyc(0, 2'd0, 1, 16'h3DFF, 0, 16'h0, 4'h0, "R6");
    cyc(0, 2'd0, 1, 16'h3E00, 0, 16'h0, 4'h0, "R6");
    // R6: wrap around top of address space
    cyc(0, 2'd0, 0, 16'h0, 1, 16'hFFFE, 4'h0, "R2");
    cyc(0, 2'd0, 1, 16'h3C05, 0, 16'h0, 4'h0, "R6");

    // R4: wrong opcode with always-condition bits is not taken
    cyc(0, 2'd0, 1, 16'h5C05, 0, 16'h0, 4'h0, "R4");
    cyc(0, 2'd0, 1, 16'h0000, 0, 16'h0, 4'h0, "R4");

    // R8: branch beats a taken jump and an advance; jump beats advance
    cyc(1, 2'd3, 1, 16'h3C10, 1, 16'h4000, 4'h0, "R8");
    cyc(1, 2'd3, 1, 16'h2010, 0, 16'h0, 4'b0100, "R8");
    cyc(1, 2'd3, 1, 16'h3C10, 0, 16'h0, 4'h0, "R8");

    // R5: every condition against every flag combination
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        cyc(0, 2'd0, 1, {3'b001, 3'(cc), 10'h004}, 0, 16'h0, 4'(f), "R5");
      end
    end

    // R9: taken drops after a following advance
    cyc(0, 2'd0, 1, 16'h3C02, 0, 16'h0, 4'h0, "R9");
    cyc(1, 2'd1, 0, 16'h0, 0, 16'h0, 4'h0, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic a, j, b;
      logic [15:0] w;
      string t;
      a = $urandom_range(0, 1);
      j = ($urandom_range(0, 2) != 0);
      b = ($urandom_range(0, 7) == 0);
      w = 16'($urandom);
      if ($urandom_range(0, 4) != 0) w[15:13] = 3'b001;
      if (b) t = (j || a) ? "R8" : "R2";
      else if (j) t = (w[15:13] == 3'b001) ? "R5" : "R4";
      else t = "R3";
      cyc(a, 2'($urandom), j, w, b, 16'($urandom), 4'($urandom), t);
    end

    // R1: reset mid-run returns to reset address
    rst = 1'b1;
    idle();
    @(posedge clk); @(negedge clk);
    check("R1", pc_o, 16'h8002, taken_o, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule